// File: doc/BRIEF.md
# Byte-port frame buffer network interface

This block sits between a processor bus and a simple network link. Software sees a small register window: two identification words, a busy flag, a receive byte count, a transmit byte count, an interrupt control register, an interrupt information word, a receive data port and a transmit data port. Frames move one byte per bus access through the data ports, and the byte counts follow each access by themselves. Each direction holds exactly one frame of at most `MAX_FRAME` bytes (1514 by default).

On the link side a frame arrives as a byte stream with valid/ready handshaking and a last-byte marker. While the block is idle, it holds `rx_ready` low only when the stored receive count is `MAX_FRAME` or more. Once the first byte of a frame has been taken, `rx_ready` stays high until the last byte, and bytes beyond `MAX_FRAME` are discarded. Outgoing frames leave on a second stream. `tx_valid`, `tx_data` and `tx_last` hold steady while `tx_ready` is low, and a byte leaves on each edge where both are high. Bus reads are registered: `bus_rdata` takes the addressed value at the edge that samples the read and holds it until the next read.

Three interrupt flags drive a level interrupt: transmit done (bit 0), receive done (bit 1) and a software test flag (bit 31). The receive buffer is shared with the incoming stream. A frame that arrives while software is still reading the previous one overwrites it.

Top module: `bnet_nic`

## Requirements
- R1: After reset, `irq` is 0, `tx_valid` is 0, `rx_ready` is 1, and busy, receive count, transmit count and interrupt control all read 0.
- R2: Word 0 reads `ID_HI`, word 1 reads `ID_LO` and word 6 reads `INFO_VAL`. The transmit data port (word 8) and unmapped words (9 to 15) read 0.
- R3: A write to the transmit count (word 4) stores the value if it is at most `MAX_FRAME` and stores 0 otherwise.
- R4: Each write to the transmit port stores `bus_wdata[7:0]` at the write index and advances the index. When the index reaches the transmit count, the frame is streamed out in write order with `tx_last` on its final byte, the transmit count reads 0 again, and transmit done (bit 0) is set.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold. Transmit port writes made while a frame is draining are dropped.
- R6: An accepted incoming frame sets the receive count to its length and sets receive done (bit 1).
- R7: Each read of the receive port (word 7) while the count is non-zero returns the next byte in arrival order, zero-extended, and decrements the count. With a count of 0 it returns 0.
- R8: With no frame in progress and a receive count of `MAX_FRAME` or more, `rx_ready` is 0 and no byte is taken. One receive port read lifts the refusal.
- R9: `irq` is high exactly when at least one of the three interrupt flags is set.
- R10: A write to interrupt control clears only transmit done if bit 0 is set. Otherwise it clears only receive done if bit 1 is set. Otherwise it sets the test flag if bit 31 is set.
- R11: A read of interrupt control returns the flags, with bit 31 for the test flag, and then clears the test flag.
- R12: Busy (word 2, bit 0) changes only on an interrupt control write, and it then takes the value "any flag set".
- R13: Writes to the identification words, the receive count, the interrupt information and the receive port change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word offset, byte address bits 5:2 |
| bus_wdata | input | 32 | Write data, data ports use bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Link takes the outgoing byte |

## Verification
A wrong receive index or count shows up on the very next receive port read: a byte is out of order, or a count readback is off by one. A lost count also shows up later as a wrong refusal on `rx_ready` once the buffer is full. A wrong transmit index fires the frame one write early or late, and `tx_valid` shows this in the cycle after the deciding write. Stale write-index state left over from a dropped drain-time write appears as a shortened next frame. A flag update in the wrong order shows on `irq` one cycle after the access, and the interrupt control and busy readbacks confirm it.

// File: rtl/bnet_pkg.sv
package bnet_pkg;
  typedef enum logic [3:0] {
    REG_ID_HI   = 4'd0,
    REG_ID_LO   = 4'd1,
    REG_BUSY    = 4'd2,
    REG_RX_LEN  = 4'd3,
    REG_TX_LEN  = 4'd4,
    REG_IRQ_CTL = 4'd5,
    REG_INFO    = 4'd6,
    REG_RX_PORT = 4'd7,
    REG_TX_PORT = 4'd8
  } reg_word_e;

  localparam int FLAG_TX   = 0;
  localparam int FLAG_RX   = 1;
  localparam int FLAG_TEST = 31;
endpackage

// File: rtl/bnet_rx_buf.sv
module bnet_rx_buf #(
  parameter int MAX_FRAME = 1514,
  localparam int CW = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          pop,
  output logic [7:0]    pop_data,
  output logic [CW-1:0] len,
  output logic          frame_done
);
  localparam int AW = $clog2(MAX_FRAME);
  localparam logic [CW-1:0] LIM = CW'(MAX_FRAME);

  logic [7:0]    mem [MAX_FRAME];
  logic          filling;
  logic [CW-1:0] wr_idx, rd_idx, len_q;
  logic          take, room;

  assign room       = wr_idx < LIM;
  assign in_ready   = filling | (len_q < LIM);
  assign take       = in_valid & in_ready;
  assign frame_done = take & in_last;
  assign len        = len_q;
  assign pop_data   = (len_q != '0) ? mem[rd_idx[AW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (take && room) mem[wr_idx[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filling <= 1'b0;
      wr_idx  <= '0;
      rd_idx  <= '0;
      len_q   <= '0;
    end else begin
      if (take) begin
        if (in_last) begin
          filling <= 1'b0;
          wr_idx  <= '0;
        end else begin
          filling <= 1'b1;
          if (room) wr_idx <= wr_idx + CW'(1);
        end
      end
      if (frame_done) begin
        len_q  <= room ? wr_idx + CW'(1) : LIM;
        rd_idx <= '0;
      end else if (pop && len_q != '0) begin
        len_q  <= len_q - CW'(1);
        rd_idx <= rd_idx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bnet_tx_buf.sv
module bnet_tx_buf #(
  parameter int MAX_FRAME = 1514,
  localparam int CW = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          len_wr,
  input  logic [31:0]   len_val,
  input  logic          push,
  input  logic [7:0]    push_data,
  output logic [CW-1:0] len,
  output logic          fire,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready
);
  localparam int AW = $clog2(MAX_FRAME);
  localparam logic [CW-1:0] LIM = CW'(MAX_FRAME);

  logic [7:0]    mem [MAX_FRAME];
  logic [CW-1:0] len_q, widx, oidx, olen;
  logic          active, push_ok;

  assign push_ok   = push & ~active & (widx < LIM);
  assign fire      = push_ok & ((widx + CW'(1)) == len_q);
  assign len       = len_q;
  assign out_valid = active;
  assign out_data  = mem[oidx[AW-1:0]];
  assign out_last  = (oidx + CW'(1)) == olen;

  always_ff @(posedge clk) begin
    if (push_ok) mem[widx[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      widx   <= '0;
      oidx   <= '0;
      olen   <= '0;
      active <= 1'b0;
    end else begin
      if (len_wr) len_q <= (len_val <= 32'(MAX_FRAME)) ? len_val[CW-1:0] : '0;
      if (fire) begin
        len_q  <= '0;
        widx   <= '0;
        oidx   <= '0;
        olen   <= len_q;
        active <= 1'b1;
      end else if (push_ok) begin
        widx <= widx + CW'(1);
      end
      if (active && out_ready) begin
        if (out_last) active <= 1'b0;
        else          oidx   <= oidx + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bnet_irq_ctl.sv
module bnet_irq_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       clr_tx_req,
  input  logic       clr_rx_req,
  input  logic       test_req,
  input  logic       rd,
  input  logic       set_tx,
  input  logic       set_rx,
  output logic [2:0] flags,
  output logic       busy,
  output logic       irq
);
  logic [2:0] nxt;

  always_comb begin
    nxt = flags;
    if (rd) nxt[2] = 1'b0;
    if (wr) begin
      if (clr_tx_req)      nxt[0] = 1'b0;
      else if (clr_rx_req) nxt[1] = 1'b0;
      else if (test_req)   nxt[2] = 1'b1;
    end
    if (set_tx) nxt[0] = 1'b1;
    if (set_rx) nxt[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      busy  <= 1'b0;
    end else begin
      flags <= nxt;
      if (wr) busy <= |nxt;
    end
  end

  assign irq = |flags;
endmodule

// File: rtl/bnet_nic.sv
module bnet_nic
  import bnet_pkg::*;
#(
  parameter int          MAX_FRAME = 1514,
  parameter logic [31:0] ID_HI     = 32'h4E49_4342,
  parameter logic [31:0] ID_LO     = 32'h5954_4531,
  parameter logic [31:0] INFO_VAL  = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [5:2]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int CW = $clog2(MAX_FRAME + 1);

  logic          rd_acc, wr_acc;
  logic          ctl_wr, ctl_rd, rx_pop, tx_len_wr, tx_push;
  logic [7:0]    rx_byte;
  logic [CW-1:0] rx_len, tx_len;
  logic          rx_done, tx_fire;
  logic [2:0]    flags;
  logic          busy_q;
  logic [31:0]   rd_mux;

  assign rd_acc    = bus_req & ~bus_we;
  assign wr_acc    = bus_req & bus_we;
  assign ctl_wr    = wr_acc && (bus_addr == REG_IRQ_CTL);
  assign ctl_rd    = rd_acc && (bus_addr == REG_IRQ_CTL);
  assign rx_pop    = rd_acc && (bus_addr == REG_RX_PORT);
  assign tx_len_wr = wr_acc && (bus_addr == REG_TX_LEN);
  assign tx_push   = wr_acc && (bus_addr == REG_TX_PORT);

  bnet_rx_buf #(.MAX_FRAME(MAX_FRAME)) u_rx (
    .clk(clk), .rst(rst),
    .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last), .in_ready(rx_ready),
    .pop(rx_pop), .pop_data(rx_byte), .len(rx_len), .frame_done(rx_done)
  );

  bnet_tx_buf #(.MAX_FRAME(MAX_FRAME)) u_tx (
    .clk(clk), .rst(rst),
    .len_wr(tx_len_wr), .len_val(bus_wdata),
    .push(tx_push), .push_data(bus_wdata[7:0]),
    .len(tx_len), .fire(tx_fire),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last), .out_ready(tx_ready)
  );

  bnet_irq_ctl u_irq (
    .clk(clk), .rst(rst),
    .wr(ctl_wr),
    .clr_tx_req(bus_wdata[FLAG_TX]), .clr_rx_req(bus_wdata[FLAG_RX]),
    .test_req(bus_wdata[FLAG_TEST]),
    .rd(ctl_rd), .set_tx(tx_fire), .set_rx(rx_done),
    .flags(flags), .busy(busy_q), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      REG_ID_HI:   rd_mux = ID_HI;
      REG_ID_LO:   rd_mux = ID_LO;
      REG_BUSY:    rd_mux = {31'b0, busy_q};
      REG_RX_LEN:  rd_mux = 32'(rx_len);
      REG_TX_LEN:  rd_mux = 32'(tx_len);
      REG_IRQ_CTL: rd_mux = {flags[2], 29'b0, flags[1], flags[0]};
      REG_INFO:    rd_mux = INFO_VAL;
      REG_RX_PORT: rd_mux = {24'b0, rx_byte};
      default:     rd_mux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/bnet_nic_chk.sv
module bnet_nic_chk
  import bnet_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_req,
  input logic       bus_we,
  input logic [5:2] bus_addr,
  input logic       irq,
  input logic       busy,
  input logic       rx_valid,
  input logic       rx_last,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_ready
);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R4
  tx_fire_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> irq);

  // R6
  rx_done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready && rx_last |=> irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !bus_req |=> irq);

  // R8
  rx_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_ready && !bus_req |=> !rx_ready);

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we && bus_addr == REG_IRQ_CTL) |=> $stable(busy));
endmodule

bind bnet_nic bnet_nic_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq(irq), .busy(busy_q),
  .rx_valid(rx_valid), .rx_last(rx_last), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/bnet_nic_test.sv
module bnet_nic_test;
  localparam int MAXF = 1514;
  localparam logic [31:0] IDH = 32'h4E49_4342;
  localparam logic [31:0] IDL = 32'h5954_4531;
  localparam logic [31:0] INF = 32'h0000_0000;
  localparam logic [3:0] W_ID_HI = 4'd0, W_ID_LO = 4'd1, W_BUSY = 4'd2, W_RXLEN = 4'd3,
                         W_TXLEN = 4'd4, W_CTL = 4'd5, W_INFO = 4'd6, W_RXP = 4'd7, W_TXP = 4'd8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, rx_ready, tx_valid, tx_last;
  logic rx_valid = 0, rx_last = 0, tx_ready = 0;
  logic [7:0] rx_data = '0, tx_data;

  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  bnet_nic uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_req = 0; d = bus_rdata;
  endtask

  task automatic read_check(input logic [3:0] a, input logic [31:0] exp, input string req, input string what);
    logic [31:0] d;
    bus_read(a, d);
    check(req, what, d, exp);
  endtask

  function automatic logic [7:0] rx_pat(input int i, input int seed);
    return 8'((i * 13 + seed) & 255);
  endfunction

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = rx_pat(i, seed); rx_last = (i == len - 1);
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic drain(input logic [7:0] exp [], input bit throttle, input bit poke, input string req);
    int idx = 0;
    logic pv = 0, pr = 0;
    logic [7:0] pd = '0;
    for (int k = 0; k < 100 && idx < exp.size(); k++) begin
      @(negedge clk);
      if (poke && k == 1) begin bus_req = 1; bus_we = 1; bus_addr = W_TXP; bus_wdata = 32'h5A; end
      if (poke && k == 2) begin bus_req = 0; bus_we = 0; end
      tx_ready = throttle ? (k % 3 != 1) : 1'b1;
      if (pv && !pr) check("R5", "held tx_data", {24'b0, tx_data}, {24'b0, pd});
      if (tx_valid && tx_ready) begin
        check(req, "tx byte", {24'b0, tx_data}, {24'b0, exp[idx]});
        check(req, "tx_last", {31'b0, tx_last}, {31'b0, idx == exp.size() - 1});
        idx++;
      end
      pv = tx_valid; pr = tx_ready; pd = tx_data;
    end
    @(negedge clk); tx_ready = 0; bus_req = 0; bus_we = 0;
    check(req, "frame length out", idx, exp.size());
    check(req, "tx_valid after frame", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_reset();
    check("R1", "irq", {31'b0, irq}, 0);
    check("R1", "tx_valid", {31'b0, tx_valid}, 0);
    check("R1", "rx_ready", {31'b0, rx_ready}, 1);
    read_check(W_BUSY, 0, "R1", "busy");
    read_check(W_RXLEN, 0, "R1", "rx count");
    read_check(W_TXLEN, 0, "R1", "tx count");
    read_check(W_CTL, 0, "R1", "irq ctl");
  endtask

  task automatic t_ident();
    read_check(W_ID_HI, IDH, "R2", "id hi");
    read_check(W_ID_LO, IDL, "R2", "id lo");
    read_check(W_INFO, INF, "R2", "info");
    read_check(W_TXP, 0, "R2", "tx port read");
    read_check(4'd12, 0, "R2", "unmapped");
  endtask

  task automatic t_txcount();
    bus_write(W_TXLEN, 2000); read_check(W_TXLEN, 0, "R3", "count 2000");
    bus_write(W_TXLEN, MAXF + 1); read_check(W_TXLEN, 0, "R3", "count max+1");
    bus_write(W_TXLEN, MAXF); read_check(W_TXLEN, MAXF, "R3", "count max");
    bus_write(W_TXLEN, 0); read_check(W_TXLEN, 0, "R3", "count 0");
  endtask

  task automatic t_tx_frame();
    logic [7:0] f4 [] = '{8'h11, 8'h22, 8'h33, 8'h44};
    logic [7:0] f2 [] = '{8'hA1, 8'hB2};
    bus_write(W_TXLEN, 4);
    for (int i = 0; i < 3; i++) bus_write(W_TXP, {24'b0, f4[i]});
    check("R4", "no fire before count", {31'b0, tx_valid}, 0);
    check("R4", "irq before fire", {31'b0, irq}, 0);
    bus_write(W_TXP, {24'hFFFFFF, f4[3]});
    check("R4", "fire on count", {31'b0, tx_valid}, 1);
    check("R9", "irq after fire", {31'b0, irq}, 1);
    drain(f4, 1'b1, 1'b1, "R4");
    read_check(W_TXLEN, 0, "R4", "count cleared");
    read_check(W_CTL, 1, "R4", "tx done flag");
    bus_write(W_CTL, 1);
    check("R9", "irq after tx clear", {31'b0, irq}, 0);
    bus_write(W_TXLEN, 2);
    bus_write(W_TXP, {24'b0, f2[0]});
    check("R5", "dropped write left no index", {31'b0, tx_valid}, 0);
    bus_write(W_TXP, {24'b0, f2[1]});
    drain(f2, 1'b0, 1'b0, "R5");
    bus_write(W_CTL, 1);
  endtask

  task automatic t_rx_frame();
    logic [31:0] d;
    send_frame(5, 7);
    check("R6", "irq after rx", {31'b0, irq}, 1);
    read_check(W_RXLEN, 5, "R6", "rx count");
    read_check(W_CTL, 2, "R6", "rx done flag");
    bus_write(W_RXLEN, 99); bus_write(W_INFO, 7); bus_write(W_RXP, 32'h33); bus_write(W_ID_HI, 0);
    read_check(W_RXLEN, 5, "R13", "rx count after writes");
    read_check(W_ID_HI, IDH, "R13", "id after write");
    read_check(W_INFO, INF, "R13", "info after write");
    for (int i = 0; i < 5; i++) begin
      bus_read(W_RXP, d);
      check("R7", "rx byte", d, {24'b0, rx_pat(i, 7)});
      if (i == 0) read_check(W_RXLEN, 4, "R7", "count after pop");
    end
    read_check(W_RXLEN, 0, "R7", "count empty");
    read_check(W_RXP, 0, "R7", "empty read");
    bus_write(W_CTL, 2);
    check("R10", "irq after rx clear", {31'b0, irq}, 0);
  endtask

  task automatic t_rx_full();
    logic [31:0] d;
    send_frame(MAXF, 3);
    check("R8", "refuse when full", {31'b0, rx_ready}, 0);
    read_check(W_RXLEN, MAXF, "R8", "full count");
    @(negedge clk); rx_valid = 1; rx_data = 8'hEE; rx_last = 1;
    repeat (3) @(negedge clk);
    check("R8", "still refusing", {31'b0, rx_ready}, 0);
    rx_valid = 0; rx_last = 0;
    read_check(W_RXLEN, MAXF, "R8", "count unchanged");
    bus_read(W_RXP, d);
    check("R8", "first byte of full frame", d, {24'b0, rx_pat(0, 3)});
    check("R8", "ready after pop", {31'b0, rx_ready}, 1);
    send_frame(2, 40);
    read_check(W_RXLEN, 2, "R6", "new frame count");
    read_check(W_RXP, {24'b0, rx_pat(0, 40)}, "R7", "new frame byte0");
    read_check(W_RXP, {24'b0, rx_pat(1, 40)}, "R7", "new frame byte1");
    bus_write(W_CTL, 2);
  endtask

  task automatic t_intctl();
    logic [7:0] f1 [] = '{8'h7E};
    bus_write(W_TXLEN, 1);
    bus_write(W_TXP, 32'h7E);
    drain(f1, 1'b0, 1'b0, "R4");
    send_frame(1, 9);
    read_check(W_CTL, 3, "R9", "both flags");
    check("R9", "irq both", {31'b0, irq}, 1);
    bus_write(W_CTL, 3);
    read_check(W_CTL, 2, "R10", "bit0 wins");
    check("R9", "irq rx only", {31'b0, irq}, 1);
    bus_write(W_CTL, 32'h8000_0002);
    read_check(W_CTL, 0, "R10", "bit1 beats test");
    check("R9", "irq none", {31'b0, irq}, 0);
    read_check(W_BUSY, 0, "R12", "busy after clear");
    bus_write(W_CTL, 32'h8000_0000);
    check("R11", "irq test", {31'b0, irq}, 1);
    read_check(W_BUSY, 1, "R12", "busy set");
    read_check(W_CTL, 32'h8000_0000, "R11", "test read");
    check("R11", "irq after test read", {31'b0, irq}, 0);
    read_check(W_CTL, 0, "R11", "test cleared");
    read_check(W_BUSY, 1, "R12", "busy kept by read");
    bus_write(W_CTL, 0);
    read_check(W_BUSY, 0, "R12", "busy after write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    t_reset();
    t_ident();
    t_txcount();
    t_tx_frame();
    t_rx_frame();
    t_rx_full();
    t_intctl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule